// File: doc/BRIEF.md
# Interrupt storm detector with polling fallback

This block sits between an error-reporting source and the interrupt controller. Each corrected-error interrupt request is timed against a sliding window that opens at a stored start tick. A request inside the window adds one to a running count. A request after the window has closed starts a new window at the current tick and sets the count back to one. While the count stays at or below the storm limit, each request produces a one-cycle service pulse that tells the handler to log the event.

When one request pushes the count past the limit, the block declares a storm. It drops the interrupt enable, raises the storm flag, and emits a single notice pulse. From then on it absorbs requests and asks for a poll once per window interval. Errors found by those polls come back on a separate input. The storm ends after a programmable number of consecutive poll intervals pass with no reported error, or at once when a software exit request arrives. Exit restores interrupt mode and clears the window state.

All tick arithmetic is modular, so the free-running tick counter may wrap anywhere without disturbing either the window or the poll timing.

Top module: `irq_storm_guard`

## Requirements
- R1: After reset, irq_en is 1, and storm_active, poll_req, service_pulse and storm_enter are all 0.
- R2: In interrupt mode, a request whose elapsed ticks (tick_now minus the window start, taken modulo 2^TICK_W) are at most win_len adds one to the count, including across a wrap of tick_now. The first request after reset or after a storm exit always opens a new window.
- R3: A request whose elapsed ticks exceed win_len sets the count to 1 and loads the window start with tick_now.
- R4: In interrupt mode, a request that leaves the count at or below STORM_LIMIT (default 15) raises service_pulse for exactly the one cycle that follows it.
- R5: The request that takes the count above STORM_LIMIT gives no service pulse. In the next cycle, storm_active is 1, irq_en is 0, and storm_enter is 1 for that single cycle only.
- R6: While storm_active is 1, requests are absorbed. They raise no service pulse and leave the window state unchanged.
- R7: In a storm, poll_req pulses for one cycle each time the elapsed ticks since storm entry, or since the previous poll, exceed win_len.
- R8: An error reported on poll_err during a poll interval, including in the cycle of the poll itself, restarts the quiet run. The storm ends at the poll that completes quiet_polls consecutive clean intervals (a value of 0 behaves as 1). Exit sets irq_en to 1 and clears the count, so the next STORM_LIMIT requests are all serviced.
- R9: exit_req ends a storm in the next cycle. In interrupt mode, exit_req and poll_err have no effect.
- R10: irq_en is always the complement of storm_active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | One-cycle error interrupt request |
| tick_now | input | TICK_W | Free-running tick count |
| win_len | input | TICK_W | Window length and poll interval in ticks |
| quiet_polls | input | QP_W | Clean poll intervals required to leave a storm |
| poll_err | input | 1 | Error found by the current poll |
| exit_req | input | 1 | Forced storm exit |
| irq_en | output | 1 | Interrupt delivery enabled |
| storm_active | output | 1 | Storm (polling) mode |
| poll_req | output | 1 | One-cycle poll request |
| service_pulse | output | 1 | One-cycle normal service request |
| storm_enter | output | 1 | One-cycle storm-entry notice |

## Verification
Two functions can land in the same cycle: an error reported on poll_err, and the poll boundary that decides whether the just-ended interval was clean. The bench drives poll_err in exactly the cycle where the elapsed ticks first exceed win_len. It then checks that poll_req still pulses, that the storm does not end at that boundary, and that exit takes a further two clean intervals. A gap sweep places the sixteenth request at every offset around the window edge, confirms that offsets up to win_len declare a storm and larger ones restart the count, and includes a run where the window wraps across the tick counter.

// File: rtl/isg_pkg.sv
package isg_pkg;
  typedef enum logic [0:0] {
    MODE_IRQ  = 1'b0,
    MODE_POLL = 1'b1
  } isg_mode_e;
endpackage

// File: rtl/isg_window.sv
// Sliding start-tick window and saturating event counter.
module isg_window #(
  parameter int TICK_W      = 16,
  parameter int STORM_LIMIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              clr,
  input  logic [TICK_W-1:0] tick_now,
  input  logic [TICK_W-1:0] win_len,
  output logic              storm_hit
);
  localparam int CNT_W = $clog2(STORM_LIMIT + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIM     = CNT_W'(STORM_LIMIT);

  logic [TICK_W-1:0] start_q, start_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              vld_q, vld_d;
  logic              upd_en;

  logic [TICK_W-1:0] elapsed;
  logic              in_win;
  logic [CNT_W-1:0]  cnt_inc;
  logic [CNT_W-1:0]  cnt_evt;

  always_comb begin
    elapsed   = tick_now - start_q;
    in_win    = vld_q && (elapsed <= win_len);
    cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    cnt_evt   = in_win ? cnt_inc : CNT_W'(1);
    storm_hit = evt && (cnt_evt > LIM);
  end

  always_comb begin
    start_d = start_q;
    cnt_d   = cnt_q;
    vld_d   = vld_q;
    upd_en  = clr || evt;
    if (clr) begin
      cnt_d = '0;
      vld_d = 1'b0;
    end else if (evt) begin
      cnt_d = cnt_evt;
      if (!in_win) begin
        start_d = tick_now;
        vld_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
    end else if (upd_en) begin
      start_q <= start_d;
      cnt_q   <= cnt_d;
      vld_q   <= vld_d;
    end
  end
endmodule

// File: rtl/isg_poll.sv
// Poll interval timer and quiet-interval counter used during a storm.
module isg_poll #(
  parameter int TICK_W = 16,
  parameter int QP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              start,
  input  logic              err,
  input  logic [TICK_W-1:0] tick_now,
  input  logic [TICK_W-1:0] win_len,
  input  logic [QP_W-1:0]   quiet_polls,
  output logic              due,
  output logic              quiet_done
);
  localparam logic [QP_W-1:0] QP_MAX = {QP_W{1'b1}};

  logic [TICK_W-1:0] mark_q, mark_d;
  logic [QP_W-1:0]   quiet_q, quiet_d;
  logic              dirty_q, dirty_d;
  logic              upd_en;

  logic [TICK_W-1:0] elapsed;
  logic              clean;
  logic [QP_W-1:0]   quiet_inc;

  always_comb begin
    elapsed    = tick_now - mark_q;
    due        = run && (elapsed > win_len);
    clean      = !(dirty_q || err);
    quiet_inc  = (quiet_q == QP_MAX) ? quiet_q : quiet_q + 1'b1;
    quiet_done = due && clean && (quiet_inc >= quiet_polls);
  end

  always_comb begin
    mark_d  = mark_q;
    quiet_d = quiet_q;
    dirty_d = dirty_q;
    upd_en  = start || run;
    if (start) begin
      mark_d  = tick_now;
      quiet_d = '0;
      dirty_d = 1'b0;
    end else if (run) begin
      if (due) begin
        mark_d  = tick_now;
        dirty_d = 1'b0;
        quiet_d = clean ? quiet_inc : '0;
      end else if (err) begin
        dirty_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q  <= '0;
      quiet_q <= '0;
      dirty_q <= 1'b0;
    end else if (upd_en) begin
      mark_q  <= mark_d;
      quiet_q <= quiet_d;
      dirty_q <= dirty_d;
    end
  end
endmodule

// File: rtl/isg_ctrl.sv
// Mode state machine and registered output pulses.
module isg_ctrl
  import isg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      irq_req,
  input  logic      storm_hit,
  input  logic      due,
  input  logic      quiet_done,
  input  logic      exit_req,
  output isg_mode_e mode_q,
  output logic      leave,
  output logic      svc_q,
  output logic      enter_q,
  output logic      poll_q
);
  isg_mode_e mode_d;
  logic      svc_d, enter_d, poll_d;
  logic      mode_en;

  always_comb begin
    mode_d  = mode_q;
    leave   = 1'b0;
    svc_d   = 1'b0;
    enter_d = 1'b0;
    poll_d  = 1'b0;
    unique case (mode_q)
      MODE_IRQ: begin
        svc_d   = irq_req && !storm_hit;
        enter_d = storm_hit;
        if (storm_hit) mode_d = MODE_POLL;
      end
      MODE_POLL: begin
        poll_d = due;
        if (quiet_done || exit_req) begin
          leave  = 1'b1;
          mode_d = MODE_IRQ;
        end
      end
      default: mode_d = MODE_IRQ;
    endcase
    mode_en = (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IRQ;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q   <= 1'b0;
      enter_q <= 1'b0;
      poll_q  <= 1'b0;
    end else begin
      svc_q   <= svc_d;
      enter_q <= enter_d;
      poll_q  <= poll_d;
    end
  end
endmodule

// File: rtl/irq_storm_guard.sv
module irq_storm_guard
  import isg_pkg::*;
#(
  parameter int TICK_W      = 16,
  parameter int STORM_LIMIT = 15,
  parameter int QP_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [TICK_W-1:0] tick_now,
  input  logic [TICK_W-1:0] win_len,
  input  logic [QP_W-1:0]   quiet_polls,
  input  logic              poll_err,
  input  logic              exit_req,
  output logic              irq_en,
  output logic              storm_active,
  output logic              poll_req,
  output logic              service_pulse,
  output logic              storm_enter
);
  isg_mode_e mode_q;
  logic      leave;
  logic      evt_irq;
  logic      in_poll;
  logic      storm_hit;
  logic      due;
  logic      quiet_done;

  assign in_poll = (mode_q == MODE_POLL);
  assign evt_irq = irq_req && !in_poll;

  isg_window #(
    .TICK_W      (TICK_W),
    .STORM_LIMIT (STORM_LIMIT)
  ) win_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt_irq),
    .clr       (leave),
    .tick_now  (tick_now),
    .win_len   (win_len),
    .storm_hit (storm_hit)
  );

  isg_poll #(
    .TICK_W (TICK_W),
    .QP_W   (QP_W)
  ) poll_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (in_poll),
    .start       (storm_hit),
    .err         (poll_err),
    .tick_now    (tick_now),
    .win_len     (win_len),
    .quiet_polls (quiet_polls),
    .due         (due),
    .quiet_done  (quiet_done)
  );

  isg_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .storm_hit  (storm_hit),
    .due        (due),
    .quiet_done (quiet_done),
    .exit_req   (exit_req),
    .mode_q     (mode_q),
    .leave      (leave),
    .svc_q      (service_pulse),
    .enter_q    (storm_enter),
    .poll_q     (poll_req)
  );

  assign irq_en       = !in_poll;
  assign storm_active = in_poll;
endmodule

// File: rtl/isg_checker.sv
module isg_checker (
  input logic clk,
  input logic rst_n,
  input logic irq_req,
  input logic exit_req,
  input logic irq_en,
  input logic storm_active,
  input logic poll_req,
  input logic service_pulse,
  input logic storm_enter
);
  assert_mode_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en != storm_active);

  assert_enter_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    storm_enter |-> $rose(storm_active));

  assert_enter_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    storm_enter |=> !storm_enter);

  assert_pulse_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({service_pulse, storm_enter}));

  assert_svc_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    service_pulse |-> (irq_en && $past(irq_req)));

  assert_absorb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (storm_active && irq_req) |=> !service_pulse);

  assert_poll_storm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req |-> $past(storm_active));

  assert_force_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (storm_active && exit_req) |=> !storm_active);
endmodule

bind irq_storm_guard isg_checker chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .irq_req       (irq_req),
  .exit_req      (exit_req),
  .irq_en        (irq_en),
  .storm_active  (storm_active),
  .poll_req      (poll_req),
  .service_pulse (service_pulse),
  .storm_enter   (storm_enter)
);

// File: tb/irq_storm_guard_tb_top.sv
`timescale 1ns/1ps
module irq_storm_guard_tb_top;
  localparam int TW  = 8;
  localparam int LIM = 15;
  localparam int QW  = 4;

  logic          clk;
  logic          rst_n;
  logic          irq_req;
  logic [TW-1:0] tick_now;
  logic [TW-1:0] win_len;
  logic [QW-1:0] quiet_polls;
  logic          poll_err;
  logic          exit_req;
  logic          irq_en, storm_active, poll_req, service_pulse, storm_enter;

  int checks = 0;
  int errors = 0;

  irq_storm_guard #(.TICK_W(TW), .STORM_LIMIT(LIM), .QP_W(QW)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_req       (irq_req),
    .tick_now      (tick_now),
    .win_len       (win_len),
    .quiet_polls   (quiet_polls),
    .poll_err      (poll_err),
    .exit_req      (exit_req),
    .irq_en        (irq_en),
    .storm_active  (storm_active),
    .poll_req      (poll_req),
    .service_pulse (service_pulse),
    .storm_enter   (storm_enter)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs at the falling edge, sample after the rising edge.
  task automatic step(input int t, input logic irq, input logic err, input logic ext);
    @(negedge clk);
    tick_now = TW'(t);
    irq_req  = irq;
    poll_err = err;
    exit_req = ext;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string req, input int svc, input int ent,
                            input int stm, input int pol);
    check(req, "service_pulse", int'(service_pulse), svc);
    check(req, "storm_enter",   int'(storm_enter),   ent);
    check(req, "storm_active",  int'(storm_active),  stm);
    check(req, "irq_en",        int'(irq_en),        1 - stm);
    check(req, "poll_req",      int'(poll_req),      pol);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_req = 0; poll_err = 0; exit_req = 0;
    tick_now = '0; win_len = TW'(20); quiet_polls = QW'(2);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    expect_out("R1", 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    step(5, 0, 0, 0);
    expect_out("R1", 0, 0, 0, 0);

    // R2/R4: 15 requests in window are serviced
    for (int i = 0; i < 15; i++) begin
      step(10 + i, 1, 0, 0);
      expect_out("R4", 1, 0, 0, 0);
    end
    // R2/R5: 16th at exactly start + win_len declares a storm
    step(30, 1, 0, 0);
    expect_out("R5", 0, 1, 1, 0);
    step(31, 0, 0, 0);
    expect_out("R5", 0, 0, 1, 0);
    // R6: absorbed request
    step(40, 1, 0, 0);
    expect_out("R6", 0, 0, 1, 0);
    // R7: elapsed 20 is not yet due, 21 is
    step(50, 0, 0, 0);
    expect_out("R7", 0, 0, 1, 0);
    step(51, 0, 0, 0);
    expect_out("R7", 0, 0, 1, 1);
    step(52, 0, 0, 0);
    expect_out("R7", 0, 0, 1, 0);
    // R8: dirty interval restarts quiet run
    step(60, 0, 1, 0);
    expect_out("R8", 0, 0, 1, 0);
    step(72, 0, 0, 0);
    expect_out("R8", 0, 0, 1, 1);
    // R8: error in the poll cycle itself
    step(93, 0, 1, 0);
    expect_out("R8", 0, 0, 1, 1);
    step(114, 0, 0, 0);
    expect_out("R8", 0, 0, 1, 1);
    step(135, 0, 0, 0);
    expect_out("R8", 0, 0, 0, 1);

    // R8: count cleared by exit
    for (int i = 0; i < 15; i++) begin
      step(140 + i, 1, 0, 0);
      expect_out("R8", 1, 0, 0, 0);
    end
    step(155, 1, 0, 0);
    expect_out("R5", 0, 1, 1, 0);
    // R9: forced exit, then exit/err ignored in interrupt mode
    step(156, 0, 0, 1);
    expect_out("R9", 0, 0, 0, 0);
    step(157, 0, 1, 1);
    expect_out("R9", 0, 0, 0, 0);

    // R3 restart and R2 wrap
    for (int i = 0; i < 15; i++) begin
      step(230 + i, 1, 0, 0);
      expect_out("R4", 1, 0, 0, 0);
    end
    step(251, 1, 0, 0);
    expect_out("R3", 1, 0, 0, 0);
    for (int i = 0; i < 14; i++) begin
      step(252 + i, 1, 0, 0);
      expect_out("R2", 1, 0, 0, 0);
    end
    step(10, 1, 0, 0);
    expect_out("R2", 0, 1, 1, 0);
    // R8: quiet_polls of 0 exits at the first clean poll
    @(negedge clk); quiet_polls = '0;
    step(20, 1, 0, 0);
    expect_out("R6", 0, 0, 1, 0);
    step(31, 0, 0, 0);
    expect_out("R8", 0, 0, 0, 1);

    // Gap sweep around the window edge with win_len 5
    @(negedge clk); win_len = TW'(5); quiet_polls = QW'(2);
    for (int g = 0; g <= 8; g++) begin
      int t0;
      t0 = 100 + 20 * g;
      for (int i = 0; i < 15; i++) begin
        step(t0, 1, 0, 0);
        expect_out("R4", 1, 0, 0, 0);
      end
      step(t0 + g, 1, 0, 0);
      if (g <= 5) begin
        expect_out("R2", 0, 1, 1, 0);
        step(t0 + g + 1, 0, 0, 1);
        expect_out("R9", 0, 0, 0, 0);
      end else begin
        expect_out("R3", 1, 0, 0, 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule